// File: doc/BRIEF.md
# Cascadable Line Data Shift-In Controller

This block gathers one display line of 6-bit gray codes for a column driver. On every rising edge of the shift clock, while a line is being filled, it takes an 18-bit word holding three codes and writes them into one three-channel group of a data register. A pointer walks across the 103 groups (309 channels), upward from channel 0 or downward from channel 308 depending on the scan direction. When the line is complete the block drops into standby and ignores the bus until a new start pulse arrives.

Several devices are chained to cover a wide panel. Each device has two start-pulse pins, modelled as separate input, output and output-enable signals. The scan direction picks which pin listens and which one passes a one-cycle start pulse on to the next device, timed so that the neighbour takes its first group on the cycle right after this device takes its last one. A rising edge on the line-load strobe copies the data register into the line latch that feeds the converters. A narrow mode drops three groups in the middle of the line, which shortens the line to 100 groups.

Top module: `lsc_line_shift`

## Requirements
- R1: Each captured 18-bit word fills one group: bits [5:0] go to the lowest channel of the group, bits [11:6] to the middle one and bits [17:12] to the highest, whatever the scan direction. Channel c appears at `line_codes[c*6 +: 6]`.
- R2: The start input is sampled on the clock edge. The first capture happens on the first edge at which the start input is low after an edge at which it was high. A pulse on the pin that is not the selected input has no effect.
- R3: With `scan_up` = 1, `cas_lo_in` is the start input, filling starts at group 0 and moves upward, and `cas_hi_oe` = 1, `cas_lo_oe` = 0. With `scan_up` = 0 the pins swap roles and filling starts at group 102 and moves downward.
- R4: After the last group of a line has been captured, the block is in standby and further clocks leave the data register unchanged until the next start pulse.
- R5: A rising edge of `line_load` copies the data register into `line_codes` on that clock edge. The same edge captures nothing and clears the pointer, so a partly filled line stops and later clocks are ignored until a start pulse.
- R6: With `narrow_mode` = 1, groups 50 to 52 (channels 150 to 158, counted from 0) are skipped, so a line takes 100 clocks. At a latch those channels read 0 and their `chan_en` bits read 0. All other `chan_en` bits read 1.
- R7: The cascade output goes high for exactly one cycle, starting at the edge that captures the second-to-last group of the line. It appears only on the output-side pin (`cas_hi_out` when scanning up, `cas_lo_out` when scanning down), and the other pin's output stays 0.
- R8: After the synchronous active-low reset, the block is in standby, `line_codes` is 0, every `chan_en` bit is 1 and both cascade outputs are 0.
- R9: A start pulse that arrives while a line is being filled restarts the fill at the first group of the current direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| px_bus | input | 18 | Three 6-bit gray codes per clock |
| line_load | input | 1 | Line-load strobe, acts on its rising edge |
| scan_up | input | 1 | 1 = fill upward from channel 0, 0 = fill downward |
| narrow_mode | input | 1 | 1 = 300-channel line that skips groups 50 to 52 |
| cas_lo_in | input | 1 | Start pin at the channel-0 end, input side |
| cas_lo_out | output | 1 | Start pin at the channel-0 end, driven value |
| cas_lo_oe | output | 1 | Output enable of the channel-0 end pin |
| cas_hi_in | input | 1 | Start pin at the top end, input side |
| cas_hi_out | output | 1 | Start pin at the top end, driven value |
| cas_hi_oe | output | 1 | Output enable of the top end pin |
| line_codes | output | 1854 | Line latch, 309 codes of 6 bits |
| chan_en | output | 309 | Per-channel enable captured at the last latch |

## Verification
The assertions assume that `scan_up` and `narrow_mode` stay steady while a line is being filled, and that a start pulse and a line-load rising edge never land on the same clock edge. They also assume the reset is held for at least one clock edge before the first checked cycle. The stimulus changes direction and mode only on the cycle that raises the start pulse, or while the block is in standby. The latch strobe is raised only after a line has ended or at a deliberate stop point, never together with a start pulse. The data words are random from a fixed seed, and the direction and mode are drawn at random for the later lines, around directed cases for a partial line, a restart in mid-line, extra clocks past the end of a line and a pulse on the wrong pin.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    // Map a logical fill position to a physical group index.
    function automatic int phys_grp(input int k, input logic up, input logic narrow,
                                    input int groups, input int skip_lo, input int skip_n);
        int p;
        if (up) begin
            p = k;
            if (narrow && k >= skip_lo) p = k + skip_n;
        end else begin
            p = groups - 1 - k;
            if (narrow && p < skip_lo + skip_n) p = p - skip_n;
        end
        return p;
    endfunction

endpackage

// File: rtl/lsc_seq.sv
module lsc_seq #(
    parameter int GROUPS  = 103,
    parameter int SKIP_LO = 50,
    parameter int SKIP_N  = 3,
    localparam int CNT_W  = $clog2(GROUPS + 1),
    localparam int GRP_W  = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_in,
    input  logic             line_load,
    input  logic             scan_up,
    input  logic             narrow_mode,
    output logic             wr_en,
    output logic [GRP_W-1:0] wr_grp,
    output logic             latch_fire,
    output logic             cas_pulse
);
    localparam int NARROW_LEN = GROUPS - SKIP_N;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        logic             load_prev;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] line_len;

    assign line_len = narrow_mode ? CNT_W'(NARROW_LEN) : CNT_W'(GROUPS);

    always_comb begin
        s_d           = s_q;
        s_d.pulse     = 1'b0;
        s_d.load_prev = line_load;
        latch_fire    = line_load & ~s_q.load_prev;
        wr_en         = 1'b0;
        if (latch_fire) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end
        if (start_in) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end else if (s_q.busy && !latch_fire) begin
            wr_en   = 1'b1;
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == line_len - CNT_W'(2)) s_d.pulse = 1'b1;
            if (s_q.cnt == line_len - CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_grp    = GRP_W'(lsc_pkg::phys_grp(int'(s_q.cnt), scan_up, narrow_mode,
                                                 GROUPS, SKIP_LO, SKIP_N));
    assign cas_pulse = s_q.pulse;

    // R7
    cascade_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pulse |=> !s_q.pulse);

    // R7
    cascade_before_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pulse |-> (s_q.busy && s_q.cnt == line_len - CNT_W'(1)));

    // R4
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !start_in) |=> !s_q.busy);

    // R1
    pointer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !start_in && !latch_fire)
        |=> (!s_q.busy || s_q.cnt == $past(s_q.cnt) + 1'b1));

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_in |=> (s_q.busy && s_q.cnt == '0));

endmodule

// File: rtl/lsc_dreg.sv
module lsc_dreg #(
    parameter int GROUPS = 103,
    parameter int GW     = 18,
    localparam int GRP_W = $clog2(GROUPS),
    localparam int REG_W = GROUPS * GW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [GW-1:0]    wr_data,
    output logic [REG_W-1:0] regs
);
    logic [REG_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d[wr_grp*GW +: GW] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    // R4
    dreg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

    // R1
    dreg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_q[$past(wr_grp)*GW +: GW] == $past(wr_data)));

endmodule

// File: rtl/lsc_latch.sv
module lsc_latch #(
    parameter int GROUPS  = 103,
    parameter int DOTS    = 3,
    parameter int CODE_W  = 6,
    parameter int SKIP_LO = 50,
    parameter int SKIP_N  = 3,
    localparam int CH     = GROUPS * DOTS,
    localparam int LINE_W = CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              narrow_mode,
    input  logic [LINE_W-1:0] regs,
    output logic [LINE_W-1:0] line_codes,
    output logic [CH-1:0]     chan_en
);
    logic [LINE_W-1:0] line_d, line_q;
    logic [CH-1:0]     en_d, en_q;
    logic [CH-1:0]     keep;
    logic [LINE_W-1:0] en_mask;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        localparam bit SKIPPED = (g >= SKIP_LO) && (g < SKIP_LO + SKIP_N);
        for (genvar d = 0; d < DOTS; d++) begin : g_dot
            assign keep[g*DOTS + d] = !(narrow_mode && SKIPPED);
        end
    end

    for (genvar c = 0; c < CH; c++) begin : g_mask
        assign en_mask[c*CODE_W +: CODE_W] = {CODE_W{en_q[c]}};
    end

    always_comb begin
        line_d = line_q;
        en_d   = en_q;
        if (fire) begin
            for (int c = 0; c < CH; c++) begin
                en_d[c]                   = keep[c];
                line_d[c*CODE_W +: CODE_W] = keep[c] ? regs[c*CODE_W +: CODE_W] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            en_q   <= '1;
        end else begin
            line_q <= line_d;
            en_q   <= en_d;
        end
    end

    assign line_codes = line_q;
    assign chan_en    = en_q;

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(line_q) && $stable(en_q)));

    // R6
    skipped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q & ~en_mask) == '0);

endmodule

// File: rtl/lsc_line_shift.sv
module lsc_line_shift #(
    parameter int GROUPS  = 103,
    parameter int DOTS    = 3,
    parameter int CODE_W  = 6,
    parameter int SKIP_LO = 50,
    parameter int SKIP_N  = 3,
    localparam int GW     = DOTS * CODE_W,
    localparam int CH     = GROUPS * DOTS,
    localparam int LINE_W = CH * CODE_W,
    localparam int GRP_W  = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GW-1:0]     px_bus,
    input  logic              line_load,
    input  logic              scan_up,
    input  logic              narrow_mode,
    input  logic              cas_lo_in,
    output logic              cas_lo_out,
    output logic              cas_lo_oe,
    input  logic              cas_hi_in,
    output logic              cas_hi_out,
    output logic              cas_hi_oe,
    output logic [LINE_W-1:0] line_codes,
    output logic [CH-1:0]     chan_en
);
    logic             start_in;
    logic             wr_en;
    logic [GRP_W-1:0] wr_grp;
    logic             latch_fire;
    logic             cas_pulse;
    logic [LINE_W-1:0] regs;

    assign start_in = scan_up ? cas_lo_in : cas_hi_in;

    lsc_seq #(.GROUPS(GROUPS), .SKIP_LO(SKIP_LO), .SKIP_N(SKIP_N)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_in(start_in), .line_load(line_load),
        .scan_up(scan_up), .narrow_mode(narrow_mode), .wr_en(wr_en),
        .wr_grp(wr_grp), .latch_fire(latch_fire), .cas_pulse(cas_pulse)
    );

    lsc_dreg #(.GROUPS(GROUPS), .GW(GW)) u_dreg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
        .wr_data(px_bus), .regs(regs)
    );

    lsc_latch #(.GROUPS(GROUPS), .DOTS(DOTS), .CODE_W(CODE_W),
                .SKIP_LO(SKIP_LO), .SKIP_N(SKIP_N)) u_latch (
        .clk(clk), .rst_n(rst_n), .fire(latch_fire), .narrow_mode(narrow_mode),
        .regs(regs), .line_codes(line_codes), .chan_en(chan_en)
    );

    assign cas_hi_out = scan_up & cas_pulse;
    assign cas_lo_out = ~scan_up & cas_pulse;
    assign cas_hi_oe  = scan_up;
    assign cas_lo_oe  = ~scan_up;

    // R7
    cascade_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cas_hi_out && cas_lo_out));

endmodule

// File: tb/lsc_line_shift_test.sv
module lsc_line_shift_test;
    localparam int NG = 103;
    localparam int NCH = 309;
    localparam int SK_LO_CH = 150;
    localparam int SK_HI_CH = 158;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [17:0] px_bus = '0;
    logic line_load = 1'b0;
    logic scan_up = 1'b1;
    logic narrow_mode = 1'b0;
    logic cas_lo_in = 1'b0, cas_hi_in = 1'b0;
    logic cas_lo_out, cas_lo_oe, cas_hi_out, cas_hi_oe;
    logic [NCH*6-1:0] line_codes;
    logic [NCH-1:0] chan_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [5:0] exp_dreg [NCH];

    always #10 clk = ~clk;

    lsc_line_shift uut (
        .clk(clk), .rst_n(rst_n), .px_bus(px_bus), .line_load(line_load),
        .scan_up(scan_up), .narrow_mode(narrow_mode),
        .cas_lo_in(cas_lo_in), .cas_lo_out(cas_lo_out), .cas_lo_oe(cas_lo_oe),
        .cas_hi_in(cas_hi_in), .cas_hi_out(cas_hi_out), .cas_hi_oe(cas_hi_oe),
        .line_codes(line_codes), .chan_en(chan_en)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int bphys(input int k, input bit up, input bit nar);
        int n = 0;
        for (int i = 0; i < NG; i++) begin
            int g;
            g = up ? i : NG - 1 - i;
            if (nar && g * 3 >= SK_LO_CH && g * 3 <= SK_HI_CH) continue;
            if (n == k) return g;
            n++;
        end
        return -1;
    endfunction

    function automatic bit skipped(input int c);
        return narrow_mode && c >= SK_LO_CH && c <= SK_HI_CH;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            px_bus = 18'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic run_line(input bit up, input bit nar, input int ngrp, input string req);
        int total;
        total = nar ? 100 : 103;
        scan_up = up;
        narrow_mode = nar;
        if (up) cas_lo_in = 1'b1; else cas_hi_in = 1'b1;
        @(negedge clk);
        cas_lo_in = 1'b0;
        cas_hi_in = 1'b0;
        chk("R3", "pin roles", {30'd0, cas_hi_oe, cas_lo_oe}, up ? 32'd2 : 32'd1);
        for (int k = 0; k < ngrp; k++) begin
            logic [17:0] v;
            logic e;
            v = 18'($urandom);
            px_bus = v;
            if (k < total) begin
                int g;
                g = bphys(k, up, nar);
                for (int d = 0; d < 3; d++) exp_dreg[g*3 + d] = v[d*6 +: 6];
            end
            e = (k == total - 1);
            if (k >= total - 3)
                chk("R7", "cascade pins", {30'd0, cas_hi_out, cas_lo_out},
                    up ? {30'd0, e, 1'b0} : {31'd0, e});
            @(negedge clk);
        end
        if (ngrp >= total)
            chk("R7", "cascade after last", {30'd0, cas_hi_out, cas_lo_out}, 32'd0);
        $display("line done: %s up=%0d narrow=%0d groups=%0d", req, up, nar, ngrp);
    endtask

    task automatic do_latch(input string req);
        int bad;
        bad = -1;
        line_load = 1'b1;
        @(negedge clk);
        line_load = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            logic [5:0] e;
            e = skipped(c) ? 6'd0 : exp_dreg[c];
            if (bad < 0 && line_codes[c*6 +: 6] !== e) bad = c;
        end
        if (bad >= 0)
            chk(req, $sformatf("line code ch %0d", bad), {26'd0, line_codes[bad*6 +: 6]},
                {26'd0, skipped(bad) ? 6'd0 : exp_dreg[bad]});
        else
            chk(req, "line codes", 32'd0, 32'd0);
        bad = -1;
        for (int c = 0; c < NCH; c++)
            if (bad < 0 && chan_en[c] !== !skipped(c)) bad = c;
        if (bad >= 0)
            chk("R6", $sformatf("chan_en ch %0d", bad), {31'd0, chan_en[bad]},
                {31'd0, !skipped(bad)});
        else
            chk("R6", "chan_en", 32'd0, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h51c3);
        for (int c = 0; c < NCH; c++) exp_dreg[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8", "line zero", {31'd0, line_codes == '0}, 32'd1);
        chk("R8", "chan_en ones", {31'd0, chan_en == '1}, 32'd1);
        chk("R8", "cascade outs", {30'd0, cas_hi_out, cas_lo_out}, 32'd0);
        idle(4);
        do_latch("R8");

        // R1 R3 R4 upward full line, extra clocks ignored
        run_line(1'b1, 1'b0, 108, "R1");
        idle(3);
        do_latch("R4");
        // R3 downward
        run_line(1'b0, 1'b0, 103, "R3");
        idle(3);
        do_latch("R3");
        // R6 narrow up and down
        run_line(1'b1, 1'b1, 100, "R6");
        idle(3);
        do_latch("R6");
        run_line(1'b0, 1'b1, 104, "R6");
        idle(3);
        do_latch("R6");
        // R1 wide after narrow: skipped groups keep their older data
        narrow_mode = 1'b0;
        @(negedge clk);
        do_latch("R1");
        // R5 partial line stopped by latch, later clocks ignored
        run_line(1'b0, 1'b0, 10, "R5");
        do_latch("R5");
        idle(6);
        do_latch("R5");
        // R2 pulse on the wrong pin
        scan_up = 1'b1;
        cas_hi_in = 1'b1;
        @(negedge clk);
        cas_hi_in = 1'b0;
        idle(8);
        do_latch("R2");
        // R9 restart in mid-line
        run_line(1'b1, 1'b0, 20, "R9");
        run_line(1'b1, 1'b0, 103, "R9");
        idle(3);
        do_latch("R9");
        // random lines
        for (int i = 0; i < 5; i++) begin
            bit up;
            bit nar;
            up = 1'($urandom);
            nar = 1'($urandom);
            run_line(up, nar, (nar ? 100 : 103) + int'($urandom % 4), "R1");
            idle(3);
            do_latch("R1");
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule